// File: doc/BRIEF.md
# Reload-Compare PWM Timer

This block is a 16-bit up-counting pulse-width generator. A running count steps once per timer tick. The tick comes from the system clock through a power-of-two clock-enable prescaler, and no derived clock is used. The count is compared against a programmable match value and a programmable reload value. When the count reaches the match value, the output moves to its active level. When the count reaches the reload value, the output falls back to its idle level, the count restarts at 0001h, and a one-cycle interrupt strobe is raised.

A polarity input selects the idle level. With polarity 0 the output idles low and is high for (reload − match) ticks of each period. With polarity 1 it idles high and is high for match ticks. The period is always reload ticks. Reload and match are captured into shadow registers. While the timer runs, new values take effect only at the next restart, so a period is never cut short or stretched. The complementary output, dead-time insertion, pin muxing and register access are handled by the surrounding logic.

Top module: `pwm_reload_timer`

## Requirements
- R1: While `en_i` is 0, from the next clock edge on: `count_o` reads 0001h, `pwm_o` equals `pol_i` (1 = idle high, 0 = idle low), `irq_o` is 0, and the prescaler phase is cleared.
- R2: With `prescale_i` = N (0..7), a tick occurs on every 2^N-th enabled cycle. The first tick falls on the 2^N-th cycle after enabling. `count_o` advances by exactly one on each tick and holds between ticks.
- R3: On a tick where the count equals the captured match value and not the captured reload value, `pwm_o` changes to the active level (the inverse of `pol_i`) at the same edge at which the count leaves the match value.
- R4: On a tick where the count equals the captured reload value, the count becomes 0001h and `pwm_o` returns to the idle level at that edge. Reaching the reload value takes priority over a match at the same count.
- R5: `irq_o` is high during exactly those cycles in which a tick occurs while the count equals the captured reload value. It is low in all other cycles.
- R6: `reload_i` and `match_i` are captured only while disabled or at the restart edge (R4). A change applied mid-period leaves the current period's length and toggle point unchanged.
- R7: With prescale 0, each period spans reload cycles. `pwm_o` is high for (reload − match) of them when `pol_i` is 0, and for match of them when `pol_i` is 1.
- R8: A match value of 0, a match value equal to the reload value, or a match value above the reload value never produces the active level: `pwm_o` stays at idle for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; 0 holds the timer at its idle state |
| pol_i | input | 1 | Idle level of the PWM output |
| reload_i | input | 16 | Period end value (count restarts at 0001h after it) |
| match_i | input | 16 | Count at which the output goes active |
| prescale_i | input | 3 | Tick divider select, divide by 2^N |
| count_o | output | 16 | Current count value |
| pwm_o | output | 1 | PWM output level |
| irq_o | output | 1 | One-cycle strobe on reaching the reload value |

## Verification
The bench builds the block with its default parameters: a 16-bit count and a 3-bit prescale select, so all eight divide ratios up to 128 are covered. Random segments use small reload values (2 to 40) with prescale mostly 0 to 3. This keeps many complete periods, restarts and mid-period shadow updates within a short run, and a few segments exercise the larger divide ratios. Match values are drawn past the reload value and include 0, which reaches the idle-only cases of R8 alongside the normal duty cycles.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned PSEL_W_DEF  = 3;

  // width of the prescale phase counter for a given select width
  function automatic int unsigned phase_width(input int unsigned sel_w);
    return (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler import pwm_timer_pkg::*; #(
  parameter int unsigned PSEL_W = PSEL_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              tick_o
);
  localparam int unsigned PH_W = phase_width(PSEL_W);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] mask;

  for (genvar i = 0; i < PH_W; i++) begin : g_mask
    assign mask[i] = (32'(sel_i) > i);
  end

  assign tick_o = en_i && (&(phase_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (!en_i) phase_q <= '0;
    else            phase_q <= phase_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_i != '0 && tick_o) |=> (!tick_o || sel_i != $past(sel_i)));
  // R1
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && sel_i != '0) |=> (!tick_o || sel_i != $past(sel_i)));
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core import pwm_timer_pkg::*; #(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, rel_q, mat_q;
  logic             capture;

  assign wrap_o  = tick_i && (cnt_q == rel_q);
  assign match_o = tick_i && (cnt_q == mat_q) && !wrap_o;
  assign capture = !en_i || wrap_o;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RESTART;
      rel_q <= '0;
      mat_q <= '0;
    end else begin
      if (capture) begin
        rel_q <= reload_i;
        mat_q <= match_i;
      end
      if (!en_i || wrap_o) cnt_q <= RESTART;
      else if (tick_i)     cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  wrap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == RESTART));
  // R2
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wrap_o && en_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
  // R6
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_o) |=> ($stable(rel_q) && $stable(mat_q)));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pol_i,
  input  logic tick_i,
  input  logic wrap_i,
  input  logic match_i,
  output logic pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pwm_q <= 1'b0;
    else if (!en_i || wrap_i)  pwm_q <= pol_i;
    else if (match_i)          pwm_q <= ~pol_i;
  end

  assign pwm_o = pwm_q;

  // R1
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pwm_q == $past(pol_i)));
  // R3
  change_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(pwm_q));
  // R4
  wrap_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap_i) |=> (pwm_q == $past(pol_i)));
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer import pwm_timer_pkg::*; #(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned PSEL_W = PSEL_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pol_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic [CNT_W-1:0]  match_i,
  input  logic [PSEL_W-1:0] prescale_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              pwm_o,
  output logic              irq_o
);
  logic tick, wrap, hit;

  pwm_prescaler #(.PSEL_W(PSEL_W)) i_pre (
    .clk_i, .rst_ni, .en_i, .sel_i(prescale_i), .tick_o(tick)
  );

  pwm_count_core #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .en_i, .tick_i(tick),
    .reload_i, .match_i, .cnt_o(count_o), .wrap_o(wrap), .match_o(hit)
  );

  pwm_out_stage i_out (
    .clk_i, .rst_ni, .en_i, .pol_i, .tick_i(tick),
    .wrap_i(wrap), .match_i(hit), .pwm_o
  );

  assign irq_o = wrap;

  // R5
  irq_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> (count_o == CNT_W'(1)));
  // R1
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);
endmodule

// File: tb/test_pwm_reload_timer.sv
module test_pwm_reload_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, pol = 1'b0;
  logic [15:0] reload = 16'd5, match = 16'd2;
  logic [2:0]  psel = 3'd0;
  logic [15:0] count;
  logic        pwm, irq;

  int total = 0, bad = 0, cyc_n = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_cnt = 16'd1, m_rel = 16'd0, m_mat = 16'd0;
  logic [6:0]  m_pre = '0;
  logic        m_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reload_timer i_pwm_reload_timer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pol_i(pol),
    .reload_i(reload), .match_i(match), .prescale_i(psel),
    .count_o(count), .pwm_o(pwm), .irq_o(irq)
  );

  function automatic logic [6:0] pmask(input logic [2:0] s);
    return 7'((8'd1 << s) - 8'd1);
  endfunction

  function automatic logic m_tick();
    return en && ((m_pre & pmask(psel)) == pmask(psel));
  endfunction

  function automatic logic m_irq();
    return m_tick() && (m_cnt == m_rel);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 16'd1; m_pre = '0; m_out = 1'b0; m_rel = '0; m_mat = '0;
    end else if (!en) begin
      m_cnt = 16'd1; m_pre = '0; m_out = pol; m_rel = reload; m_mat = match;
    end else begin
      logic t;
      t = m_tick();
      m_pre = m_pre + 7'd1;
      if (t) begin
        if (m_cnt == m_rel) begin
          m_cnt = 16'd1; m_out = pol; m_rel = reload; m_mat = match;
        end else begin
          if (m_cnt == m_mat) m_out = ~pol;
          m_cnt = m_cnt + 16'd1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  // one clock, then compare all outputs with the reference
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
    cyc_n++;
    if (!en) begin
      chk("R1 count idle", 32'(count), 32'd1);
      chk("R1 pwm idle", 32'(pwm), 32'(pol));
    end else begin
      chk("R2/R4 count", 32'(count), 32'(m_cnt));
      chk("R3/R4 pwm", 32'(pwm), 32'(m_out));
    end
    chk("R5 irq", 32'(irq), 32'(m_irq()));
  endtask

  task automatic wait_irq(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      step();
      if (irq) seen = 1;
    end
  endtask

  // R7/R8: measure high cycles over one full period, prescale 0
  task automatic duty(input logic p, input logic [15:0] r, input logic [15:0] mt,
                      input int exp_hi, input string tag);
    bit seen;
    int hi, irqs;
    en = 0; pol = p; reload = r; match = mt; psel = 0;
    step(); step();
    en = 1;
    wait_irq(seen);
    chk({tag, " irq seen"}, 32'(seen), 32'd1);
    hi = 0; irqs = 0;
    for (int i = 0; i < r; i++) begin
      step();
      if (pwm) hi++;
      if (irq) irqs++;
    end
    chk({tag, " high cycles"}, 32'(hi), 32'(exp_hi));
    chk({tag, " one irq per period"}, 32'(irqs), 32'd1);
    chk({tag, " irq on last cycle"}, 32'(irq), 32'd1);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      if (cyc_n > WDOG_LIMIT) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cyc_n, WDOG_LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    bit seen;
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b1;
    pol = 1'b1;
    step();
    // R1: reset and disabled state
    chk("R1 reset count", 32'(count), 32'd1);
    chk("R1 pwm idle high", 32'(pwm), 32'd1);
    chk("R1 irq low", 32'(irq), 32'd0);
    pol = 1'b0;
    step();
    chk("R1 pwm idle low", 32'(pwm), 32'd0);

    // R2: first tick timing with divide by 4
    psel = 3'd2; reload = 16'd100; match = 16'd50;
    en = 1;
    step(); step(); step();
    chk("R2 no tick before 4th cycle", 32'(count), 32'd1);
    step();
    chk("R2 first tick on 4th cycle", 32'(count), 32'd2);
    repeat (4) step();
    chk("R2 next tick after 4 more", 32'(count), 32'd3);

    // R3 / R4 directed edges, prescale 0, pol 0
    en = 0; psel = 0; reload = 16'd6; match = 16'd3; pol = 0;
    step();
    en = 1;
    step(); step();
    chk("R3 low before match", 32'(pwm), 32'd0);
    step();
    chk("R3 high after leaving match", 32'(pwm), 32'd1);
    chk("R3 count after match", 32'(count), 32'd4);
    step(); step();
    chk("R5 irq at reload", 32'(irq), 32'd1);
    step();
    chk("R4 count restarts at 1", 32'(count), 32'd1);
    chk("R4 pwm back to idle", 32'(pwm), 32'd0);

    // R6: mid-period change does not alter the running period
    reload = 16'd20; match = 16'd1;
    wait_irq(seen);
    chk("R6 old reload kept", 32'(count), 32'd6);
    wait_irq(seen);
    chk("R6 new reload after restart", 32'(count), 32'd20);

    // R7 duty cycles
    duty(1'b0, 16'd10, 16'd3, 7, "R7 pol0");
    duty(1'b1, 16'd10, 16'd3, 3, "R7 pol1");
    duty(1'b0, 16'd17, 16'd16, 1, "R7 pol0 narrow");
    // R8 idle-only cases
    duty(1'b0, 16'd8, 16'd0, 0, "R8 match zero");
    duty(1'b0, 16'd8, 16'd8, 0, "R8 match equals reload");
    duty(1'b1, 16'd8, 16'd9, 8, "R8 match above reload");

    // R2 largest divider
    en = 0; psel = 3'd7; reload = 16'd2; match = 16'd1; pol = 0;
    step();
    en = 1;
    repeat (127) step();
    chk("R2 div128 no tick yet", 32'(count), 32'd1);
    step();
    chk("R2 div128 first tick", 32'(count), 32'd2);

    // random segments with mid-run changes
    for (int s = 0; s < 40; s++) begin
      en     = ($urandom % 8) != 0;
      pol    = 1'($urandom);
      psel   = (($urandom % 6) == 0) ? 3'($urandom) : 3'($urandom % 4);
      reload = 16'(2 + $urandom % 39);
      match  = 16'($urandom % 46);
      for (int c = 0; c < 300; c++) begin
        step();
        if (($urandom % 97) == 0) reload = 16'(2 + $urandom % 39);
        if (($urandom % 89) == 0) match  = 16'($urandom % 46);
        if (($urandom % 211) == 0) pol   = ~pol;
        if (($urandom % 257) == 0) en    = ~en;
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule